// File: doc/BRIEF.md
# Host Command and Interrupt Status Register

This block is the host-facing command and status register pair of a descriptor-driven network controller. The host writes a 16-bit command word that holds an opcode for the command engine, an opcode for the receive engine, an interrupt mask bit and a software-interrupt request bit. Each opcode is held and offered to its engine until that engine accepts it. Until then the field reads back nonzero, so software polls the command word for zero before it issues the next command. A 32-bit pointer register is written first and is captured with each opcode as it is issued.

Engine events arrive as one-cycle pulses and set sticky bits in the upper byte of the status word. The host acknowledges them by writing ones. Any set event bit raises the single interrupt output unless the mask bit is on. The lower byte of the status word reports the current state of the two engines. The register port accepts every access in the cycle it is offered, and read data is a combinational function of the address.

Top module: `cmd_stat_regs`

## Requirements
- R1: After reset the event bits, both opcode fields, the mask bit and the held pointers are zero, and `irq` is low.
- R2: A pulse on `evtPulse[i]` sets status bit 8+i on the next clock edge, for i in {7,6,5,4,3,0}: 15 command done, 14 frame received, 13 command engine left active, 12 receiver not ready, 11 management cycle done, 8 flow-control pause. Pulses on `evtPulse[2]` and `evtPulse[1]` have no effect.
- R3: A write to the status word (address 0) clears each event bit at a position where the data has a one, inside mask 0xFD00. Zero bits leave event bits unchanged. An event pulse in the same cycle as its clear leaves the bit set.
- R4: A command-word write (address 1) with a nonzero bits 7:4 loads the command-engine opcode (0 no-op, 1 start, 2 resume, 4 load statistics address, 5 dump statistics, 6 load base, 7 dump and reset). The opcode reads back at bits 7:4 and drives `cuCmdValid`/`cuCmdOp` until the clock edge at which `cuAccept` is high, after which it reads zero.
- R5: Bits 2:0 of the command word load the receive-engine opcode the same way (0 no-op, 1 start, 2 resume, 4 abort, 6 load base, 7 resume without resources). It is offered on `ruCmdValid`/`ruCmdOp` and clears on `ruAccept`, independently of the command-engine field.
- R6: The pointer register (address 2) is captured into `cuCmdPtr` or `ruCmdPtr` when that field is loaded. Later pointer writes do not change a held pointer.
- R7: A nonzero opcode written to a field that is still pending is dropped, and the held opcode and pointer stay. A zero opcode never cancels a pending one.
- R8: Bit 8 of every command-word write sets the mask, which reads back at bit 8. `irq` is high exactly when any event bit is set and the mask is clear.
- R9: Writing bit 9 of the command word as one sets status bit 10 (software interrupt). Bit 9 reads back as zero.
- R10: Status bits 7:6 show `cuState` and bits 5:2 show `ruState`. Status bits 9, 1 and 0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access offered |
| regWrite | input | 1 | Access is a write |
| regAddr | input | 2 | 0 status, 1 command, 2 pointer |
| regWdata | input | 32 | Write data |
| regReady | output | 1 | Access accepted (always) |
| regRdata | output | 32 | Read data for regAddr |
| evtPulse | input | 8 | Event pulses, index i maps to status bit 8+i |
| cuState | input | 2 | Command engine state |
| ruState | input | 4 | Receive engine state |
| cuCmdValid | output | 1 | Command engine opcode pending |
| cuCmdOp | output | 4 | Pending command engine opcode |
| cuCmdPtr | output | 32 | Pointer captured with it |
| cuAccept | input | 1 | Command engine takes the opcode |
| ruCmdValid | output | 1 | Receive engine opcode pending |
| ruCmdOp | output | 3 | Pending receive engine opcode |
| ruCmdPtr | output | 32 | Pointer captured with it |
| ruAccept | input | 1 | Receive engine takes the opcode |
| irq | output | 1 | Interrupt request |

## Verification
Events are raised with an all-ones pulse vector, which shows both the mapped bits and the two unmapped positions. They are then acknowledged with a partial mask, a zero write and a full write, which separates write-one-to-clear from plain writes and from lost bits. Commands are issued to one engine, then to both at once with only one accepting, which shows whether the fields clear independently. Each held opcode is then hit with a write while busy and with pointer rewrites, which exposes overwrites of pending state. Mask toggling with a pending event and a same-cycle pulse-and-clear show the interrupt gating and the set-over-clear priority.

// File: rtl/cmd_stat_pkg.sv
package cmd_stat_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int EVT_W = 8;
  localparam int CU_OP_W = 4;
  localparam int RU_OP_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMD    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PTR    = 2'd2;
  // event positions driven from outside (status bits 15..11 and 8)
  localparam logic [EVT_W-1:0] EXT_EVT_MASK = 8'b1111_1001;
  // all acknowledgeable positions (status bits 15..10 and 8)
  localparam logic [EVT_W-1:0] ACK_MASK = 8'b1111_1101;
  localparam int SWI_IDX = 2;

  typedef struct packed {
    logic wrStatus;
    logic wrCmd;
    logic wrPtr;
    logic cuLoad;
    logic ruLoad;
    logic cuClear;
    logic ruClear;
    logic swiSet;
  } ctl_strobes_t;
endpackage

// File: rtl/cmd_stat_ctrl.sv
module cmd_stat_ctrl
  import cmd_stat_pkg::*;
(
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CU_OP_W-1:0] cuOpIn,
  input  logic [RU_OP_W-1:0] ruOpIn,
  input  logic               swiIn,
  input  logic               cuBusy,
  input  logic               ruBusy,
  input  logic               cuAccept,
  input  logic               ruAccept,
  output ctl_strobes_t       strobes
);
  logic wrEn;

  always_comb begin
    wrEn = regValid && regWrite;
    strobes.wrStatus = wrEn && (regAddr == ADDR_STATUS);
    strobes.wrCmd    = wrEn && (regAddr == ADDR_CMD);
    strobes.wrPtr    = wrEn && (regAddr == ADDR_PTR);
    // a field only loads when idle; a zero opcode never loads
    strobes.cuLoad   = strobes.wrCmd && (cuOpIn != '0) && !cuBusy;
    strobes.ruLoad   = strobes.wrCmd && (ruOpIn != '0) && !ruBusy;
    strobes.cuClear  = cuAccept && cuBusy;
    strobes.ruClear  = ruAccept && ruBusy;
    strobes.swiSet   = strobes.wrCmd && swiIn;
  end
endmodule

// File: rtl/cmd_stat_dpath.sv
module cmd_stat_dpath
  import cmd_stat_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_strobes_t       strobes,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [EVT_W-1:0]   evtPulse,
  input  logic [1:0]         cuState,
  input  logic [3:0]         ruState,
  output logic [DATA_W-1:0]  regRdata,
  output logic [EVT_W-1:0]   evtBits,
  output logic               maskOn,
  output logic               cuBusy,
  output logic               ruBusy,
  output logic [CU_OP_W-1:0] cuOp,
  output logic [RU_OP_W-1:0] ruOp,
  output logic [PTR_W-1:0]   cuPtr,
  output logic [PTR_W-1:0]   ruPtr
);
  logic [PTR_W-1:0] ptrReg;
  logic [EVT_W-1:0] evtSet;
  logic [EVT_W-1:0] evtClr;

  always_comb begin
    evtSet = evtPulse & EXT_EVT_MASK;
    evtSet[SWI_IDX] = strobes.swiSet;
    evtClr = strobes.wrStatus ? (regWdata[15:8] & ACK_MASK) : '0;
  end

  // set wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) evtBits <= '0;
    else       evtBits <= (evtBits & ~evtClr) | evtSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg <= '0;
      maskOn <= 1'b0;
    end else begin
      if (strobes.wrPtr) ptrReg <= regWdata[PTR_W-1:0];
      if (strobes.wrCmd) maskOn <= regWdata[8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cuOp  <= '0;
      cuPtr <= '0;
    end else if (strobes.cuClear) begin
      cuOp <= '0;
    end else if (strobes.cuLoad) begin
      cuOp  <= regWdata[7:4];
      cuPtr <= ptrReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ruOp  <= '0;
      ruPtr <= '0;
    end else if (strobes.ruClear) begin
      ruOp <= '0;
    end else if (strobes.ruLoad) begin
      ruOp  <= regWdata[2:0];
      ruPtr <= ptrReg;
    end
  end

  assign cuBusy = (cuOp != '0);
  assign ruBusy = (ruOp != '0);

  always_comb begin
    unique case (regAddr)
      ADDR_STATUS: regRdata = {16'h0, evtBits, cuState, ruState, 2'b00};
      ADDR_CMD:    regRdata = {23'h0, maskOn, cuOp, 1'b0, ruOp};
      ADDR_PTR:    regRdata = DATA_W'(ptrReg);
      default:     regRdata = '0;
    endcase
  end
endmodule

// File: rtl/cmd_stat_regs.sv
module cmd_stat_regs
  import cmd_stat_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic               regReady,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [EVT_W-1:0]   evtPulse,
  input  logic [1:0]         cuState,
  input  logic [3:0]         ruState,
  output logic               cuCmdValid,
  output logic [CU_OP_W-1:0] cuCmdOp,
  output logic [PTR_W-1:0]   cuCmdPtr,
  input  logic               cuAccept,
  output logic               ruCmdValid,
  output logic [RU_OP_W-1:0] ruCmdOp,
  output logic [PTR_W-1:0]   ruCmdPtr,
  input  logic               ruAccept,
  output logic               irq
);
  ctl_strobes_t     strobes;
  logic [EVT_W-1:0] evtBits;
  logic             maskOn;
  logic             cuBusy;
  logic             ruBusy;

  cmd_stat_ctrl u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .cuOpIn   (regWdata[7:4]),
    .ruOpIn   (regWdata[2:0]),
    .swiIn    (regWdata[9]),
    .cuBusy   (cuBusy),
    .ruBusy   (ruBusy),
    .cuAccept (cuAccept),
    .ruAccept (ruAccept),
    .strobes  (strobes)
  );

  cmd_stat_dpath #(.PTR_W(PTR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWdata (regWdata),
    .regAddr  (regAddr),
    .evtPulse (evtPulse),
    .cuState  (cuState),
    .ruState  (ruState),
    .regRdata (regRdata),
    .evtBits  (evtBits),
    .maskOn   (maskOn),
    .cuBusy   (cuBusy),
    .ruBusy   (ruBusy),
    .cuOp     (cuCmdOp),
    .ruOp     (ruCmdOp),
    .cuPtr    (cuCmdPtr),
    .ruPtr    (ruCmdPtr)
  );

  assign regReady   = 1'b1;
  assign cuCmdValid = cuBusy;
  assign ruCmdValid = ruBusy;
  assign irq        = (|evtBits) && !maskOn;
endmodule

// File: rtl/cmd_stat_regs_chk.sv
module cmd_stat_regs_chk #(
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regValid,
  input logic             regWrite,
  input logic [1:0]       regAddr,
  input logic [31:0]      regWdata,
  input logic [7:0]       evtPulse,
  input logic [7:0]       evtBits,
  input logic             maskOn,
  input logic             irq,
  input logic             cuCmdValid,
  input logic             cuAccept,
  input logic [3:0]       cuCmdOp,
  input logic [PTR_W-1:0] cuCmdPtr,
  input logic             ruCmdValid,
  input logic             ruAccept,
  input logic [2:0]       ruCmdOp,
  input logic [PTR_W-1:0] ruCmdPtr
);
  assert_evt_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse[7] |=> evtBits[7]);

  assert_evt_unmapped_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!evtBits[1]));

  assert_ack_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr == 2'd0 && regWdata[14] && !evtPulse[6])
    |=> !evtBits[6]);

  assert_cu_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cuCmdValid && cuAccept) |=> !cuCmdValid);

  assert_cu_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cuCmdValid && !cuAccept) |=> (cuCmdValid && $stable(cuCmdOp)));

  assert_ru_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ruCmdValid && !ruAccept) |=> (ruCmdValid && $stable(ruCmdOp)));

  assert_ru_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ruCmdValid && ruAccept) |=> !ruCmdValid);

  assert_ptr_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cuCmdValid && !cuAccept) |=> $stable(cuCmdPtr));

  assert_ru_ptr_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ruCmdValid && !ruAccept) |=> $stable(ruCmdPtr));

  assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    maskOn |-> !irq);

  assert_swi_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr == 2'd1 && regWdata[9]) |=> evtBits[2]);
endmodule

bind cmd_stat_regs cmd_stat_regs_chk #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regValid   (regValid),
  .regWrite   (regWrite),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .evtPulse   (evtPulse),
  .evtBits    (evtBits),
  .maskOn     (maskOn),
  .irq        (irq),
  .cuCmdValid (cuCmdValid),
  .cuAccept   (cuAccept),
  .cuCmdOp    (cuCmdOp),
  .cuCmdPtr   (cuCmdPtr),
  .ruCmdValid (ruCmdValid),
  .ruAccept   (ruAccept),
  .ruCmdOp    (ruCmdOp),
  .ruCmdPtr   (ruCmdPtr)
);

// File: tb/tb_cmd_stat_regs.sv
`timescale 1ns/1ps
module tb_cmd_stat_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic        regReady;
  logic [31:0] regRdata;
  logic [7:0]  evtPulse = '0;
  logic [1:0]  cuState = '0;
  logic [3:0]  ruState = '0;
  logic        cuCmdValid, ruCmdValid;
  logic [3:0]  cuCmdOp;
  logic [2:0]  ruCmdOp;
  logic [31:0] cuCmdPtr, ruCmdPtr;
  logic        cuAccept = 1'b0;
  logic        ruAccept = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  cmd_stat_regs dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regReady(regReady),
    .regRdata(regRdata), .evtPulse(evtPulse), .cuState(cuState),
    .ruState(ruState), .cuCmdValid(cuCmdValid), .cuCmdOp(cuCmdOp),
    .cuCmdPtr(cuCmdPtr), .cuAccept(cuAccept), .ruCmdValid(ruCmdValid),
    .ruCmdOp(ruCmdOp), .ruCmdPtr(ruCmdPtr), .ruAccept(ruAccept), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk);
    evtPulse = p;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic acceptCu();
    @(negedge clk); cuAccept = 1'b1;
    @(negedge clk); cuAccept = 1'b0;
  endtask

  task automatic acceptRu();
    @(negedge clk); ruAccept = 1'b1;
    @(negedge clk); ruAccept = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 status", d, 32'h0);
    rd(2'd1, d); check("R1 command", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 cuCmdValid", {31'b0, cuCmdValid}, 32'h0);
    check("R1 cuCmdPtr", cuCmdPtr, 32'h0);
    check("R1 regReady", {31'b0, regReady}, 32'h1);
  endtask

  task automatic testEvents();
    logic [31:0] d;
    pulse(8'hFF);
    rd(2'd0, d); check("R2 mapped bits set, 9 and 10 untouched", d, 32'h0000_F900);
    check("R8 irq with event unmasked", {31'b0, irq}, 32'h1);
  endtask

  task automatic testAck();
    logic [31:0] d;
    wr(2'd0, 32'h0000_4100);
    rd(2'd0, d); check("R3 partial ack", d, 32'h0000_B800);
    wr(2'd0, 32'h0);
    rd(2'd0, d); check("R3 zero write no effect", d, 32'h0000_B800);
    wr(2'd0, 32'h0000_FFFF);
    rd(2'd0, d); check("R3 full ack", d, 32'h0);
    check("R8 irq low when no events", {31'b0, irq}, 32'h0);
    // pulse and clear of bit 15 in the same cycle
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = 2'd0; regWdata = 32'h8000;
    evtPulse = 8'h80;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0; regWdata = '0; evtPulse = '0;
    rd(2'd0, d); check("R3 set wins over clear", d, 32'h0000_8000);
    wr(2'd0, 32'h8000);
    rd(2'd0, d); check("R3 cleared afterwards", d, 32'h0);
  endtask

  task automatic testCu();
    logic [31:0] d;
    wr(2'd2, 32'h1234_5678);
    wr(2'd1, 32'h0000_0010);
    rd(2'd1, d); check("R4 opcode reads back busy", d, 32'h0000_0010);
    check("R4 cuCmdValid", {31'b0, cuCmdValid}, 32'h1);
    check("R4 cuCmdOp start", {28'b0, cuCmdOp}, 32'h1);
    check("R5 ru idle", {31'b0, ruCmdValid}, 32'h0);
    check("R6 pointer captured", cuCmdPtr, 32'h1234_5678);
    wr(2'd2, 32'hAAAA_5555);
    check("R6 later pointer write ignored", cuCmdPtr, 32'h1234_5678);
    rd(2'd2, d); check("R6 pointer register readback", d, 32'hAAAA_5555);
    wr(2'd1, 32'h0000_0050);
    check("R7 write while busy dropped", {28'b0, cuCmdOp}, 32'h1);
    check("R7 pointer kept", cuCmdPtr, 32'h1234_5678);
    wr(2'd1, 32'h0);
    check("R7 zero opcode does not cancel", {31'b0, cuCmdValid}, 32'h1);
    acceptCu();
    rd(2'd1, d); check("R4 cleared after accept", d, 32'h0);
    check("R4 cuCmdValid low", {31'b0, cuCmdValid}, 32'h0);
  endtask

  task automatic testBoth();
    logic [31:0] d;
    wr(2'd2, 32'hCAFE_0000);
    wr(2'd1, 32'h0000_0061);
    rd(2'd1, d); check("R5 both fields busy", d, 32'h0000_0061);
    check("R5 ruCmdPtr", ruCmdPtr, 32'hCAFE_0000);
    check("R6 cuCmdPtr new", cuCmdPtr, 32'hCAFE_0000);
    acceptRu();
    rd(2'd1, d); check("R5 ru clears alone", d, 32'h0000_0060);
    check("R5 ruCmdValid low", {31'b0, ruCmdValid}, 32'h0);
    wr(2'd1, 32'h0000_0004);
    rd(2'd1, d); check("R5 abort loads while cu busy", d, 32'h0000_0064);
    check("R5 ruCmdOp abort", {29'b0, ruCmdOp}, 32'h4);
    acceptCu();
    rd(2'd1, d); check("R4 cu clears alone", d, 32'h0000_0004);
    acceptRu();
    rd(2'd1, d); check("R5 all idle", d, 32'h0);
  endtask

  task automatic testMask();
    logic [31:0] d;
    pulse(8'h01);
    check("R8 irq from bit 8 event", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h0000_0100);
    check("R8 masked irq low", {31'b0, irq}, 32'h0);
    rd(2'd1, d); check("R8 mask readback", d, 32'h0000_0100);
    wr(2'd1, 32'h0);
    check("R8 unmasked irq high", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0100);
    check("R8 irq low after ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic testSwi();
    logic [31:0] d;
    wr(2'd1, 32'h0000_0200);
    rd(2'd0, d); check("R9 software event at bit 10", d, 32'h0000_0400);
    rd(2'd1, d); check("R9 bit 9 reads zero", d, 32'h0);
    check("R9 irq from software event", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0400);
    rd(2'd0, d); check("R3 software event acked", d, 32'h0);
  endtask

  task automatic testState();
    logic [31:0] d;
    @(negedge clk);
    cuState = 2'b10; ruState = 4'b1010;
    rd(2'd0, d); check("R10 engine states", d, 32'h0000_00A8);
    cuState = 2'b01; ruState = 4'b0101;
    rd(2'd0, d); check("R10 engine states alt", d, 32'h0000_0054);
    cuState = '0; ruState = '0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        testReset();
        testEvents();
        testAck();
        testCu();
        testBoth();
        testMask();
        testSwi();
        testState();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule